// File: doc/BRIEF.md
# DRP Register Bridge

This block sits on a word-wide register bus and gives a processor access to the dynamic reconfiguration port of a clock synthesizer. A small register window holds two control bits for the synthesizer (core reset release and synthesizer enable), a clock-source select bit, a command register and a status register.

A single write to the command register encodes one port transaction and launches it: target address, write data and direction all travel in the same bus word. The block then drives a one-cycle enable on the port and shows busy in the status word until the port answers with ready. For a read, the returned half-word is kept in the low bits of the status word. Software polls status until busy drops, then issues the next command or collects the read data.

Bus reads are combinational: `busRdData` always shows the register selected by `busAddr`. Bus writes take effect on the rising clock edge while `busWrEn` is high.

Top module: `drp_bridge`

## Requirements
- R1: While reset is applied and after it is released, every mapped register reads as zero and all port outputs, `coreRelease`, `synthEnable` and `srcSel` are low.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `coreRelease` and bit 1 drives `synthEnable`, so 0x1 releases the core with the synthesizer off and 0x3 turns it on. Reading 0x40 returns the two bits in place, with zeros above.
- R3: A write to offset 0x44 stores bit 0 as the source select on `srcSel`. Reading 0x44 returns it in bit 0, with zeros above.
- R4: A write to offset 0x70 with bit 29 set, while not busy, makes `drpEn` high for exactly the next cycle. In that cycle `drpWe` is the inverse of bit 28, and from then on `drpAddr` holds bits 22:16 and `drpWrData` holds bits 15:0 of the written word. `drpWe` is never high without `drpEn`.
- R5: Status at offset 0x74 shows busy in bit 16. Busy is set by the same edge that launches a transaction.
- R6: Busy clears on the edge where `drpRdy` is sampled high while busy. `drpRdy` while not busy has no effect.
- R7: On the completing edge of a read (bit 28 set at launch), `drpRdData` is stored in status bits 15:0. Completion of a write leaves those bits unchanged.
- R8: A command write that arrives while busy is set at that edge is ignored: no enable pulse, no change to `drpAddr`, `drpWrData`, command readback or status.
- R9: A command write with bit 29 clear launches nothing and changes nothing. Reading 0x70 returns the last accepted command: bit 29, bit 28, address in bits 22:16 and data in bits 15:0.
- R10: Reads of any unmapped offset return zero, and writes to one change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | BUS_AW | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, one word per cycle |
| busWrData | input | BUS_DW | Write data |
| busRdData | output | BUS_DW | Read data for `busAddr` (combinational) |
| coreRelease | output | 1 | Core reset release (0x40 bit 0) |
| synthEnable | output | 1 | Synthesizer enable (0x40 bit 1) |
| srcSel | output | 1 | Clock source index (0x44 bit 0) |
| drpEn | output | 1 | One-cycle transaction enable |
| drpWe | output | 1 | Write enable, only with `drpEn` |
| drpAddr | output | DRP_AW | Port register address |
| drpWrData | output | DRP_DW | Port write data |
| drpRdy | input | 1 | Port completion |
| drpRdData | input | DRP_DW | Port read data |

## Verification
A wrong busy state shows up at the ports within one cycle. A stuck-busy bridge swallows the next command, so no `drpEn` follows. A busy that drops early accepts a second command before the port has answered, and the extra pulse shows up at once. A wrong read-pending flag shows in status bits 15:0 right after the completing edge: read data is missing, or a write completion overwrites the data. The bench compares every output and the addressed readback against a behavioural model on every cycle. It uses varied ready delays, ready pulses while idle, and commands issued while busy, so each of these faults shows up in the cycle it occurs.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  // register offsets (bytes)
  localparam int OFF_SYS    = 'h40;
  localparam int OFF_SRC    = 'h44;
  localparam int OFF_CMD    = 'h70;
  localparam int OFF_STAT   = 'h74;
  // command word fields
  localparam int CMD_GO_BIT = 29;
  localparam int CMD_RD_BIT = 28;
  localparam int CMD_A_LSB  = 16;
  // status word fields
  localparam int STAT_BUSY  = 16;

  typedef struct packed {
    logic launch;   // command accepted this edge
    logic capture;  // read completes this edge
  } drpStrobes_t;
endpackage

// File: rtl/drp_bridge_ctrl.sv
module drp_bridge_ctrl
  import drp_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdReq,
  input  logic        cmdIsRead,
  input  logic        drpRdy,
  output drpStrobes_t strb,
  output logic        busy,
  output logic        drpEn,
  output logic        drpWe
);
  typedef enum logic {ST_IDLE, ST_WAIT} txState_t;

  txState_t state;
  logic     pendRead;
  logic     launch;
  logic     finish;

  assign launch       = (state == ST_IDLE) && cmdReq;
  assign finish       = (state == ST_WAIT) && drpRdy;
  assign strb.launch  = launch;
  assign strb.capture = finish && pendRead;
  assign busy         = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendRead <= 1'b0;
      drpEn    <= 1'b0;
      drpWe    <= 1'b0;
    end else begin
      drpEn <= launch;
      drpWe <= launch && !cmdIsRead;
      if (launch) begin
        state    <= ST_WAIT;
        pendRead <= cmdIsRead;
      end else if (finish) begin
        state    <= ST_IDLE;
        pendRead <= 1'b0;
      end
    end
  end

  // R4
  en_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    drpEn |=> !drpEn);
  // R4
  we_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    drpWe |-> drpEn);
  // R5
  en_implies_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    drpEn |-> busy);
  // R6
  busy_drop_on_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(drpRdy));
endmodule

// File: rtl/drp_bridge_dp.sv
module drp_bridge_dp
  import drp_bridge_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int BUS_DW = 32,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_DW-1:0] busWrData,
  output logic [BUS_DW-1:0] busRdData,
  input  drpStrobes_t       strb,
  input  logic              busy,
  output logic              cmdReq,
  output logic              cmdIsRead,
  output logic              coreRelease,
  output logic              synthEnable,
  output logic              srcSel,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpWrData,
  input  logic [DRP_DW-1:0] drpRdData
);
  localparam logic [BUS_AW-1:0] A_SYS  = BUS_AW'(OFF_SYS);
  localparam logic [BUS_AW-1:0] A_SRC  = BUS_AW'(OFF_SRC);
  localparam logic [BUS_AW-1:0] A_CMD  = BUS_AW'(OFF_CMD);
  localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(OFF_STAT);

  logic [1:0]        sysBits;
  logic              srcBit;
  logic              cmdGo;
  logic              cmdRd;
  logic [DRP_AW-1:0] cmdAddr;
  logic [DRP_DW-1:0] cmdData;
  logic [DRP_DW-1:0] statData;
  logic              launchW;
  logic              captureW;
  logic              unusedWrBits;

  assign launchW      = strb.launch;
  assign captureW     = strb.capture;
  assign unusedWrBits = ^busWrData;

  assign cmdReq      = busWrEn && (busAddr == A_CMD) && busWrData[CMD_GO_BIT];
  assign cmdIsRead   = busWrData[CMD_RD_BIT];
  assign coreRelease = sysBits[0];
  assign synthEnable = sysBits[1];
  assign srcSel      = srcBit;
  assign drpAddr     = cmdAddr;
  assign drpWrData   = cmdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysBits <= '0;
      srcBit  <= 1'b0;
    end else if (busWrEn) begin
      if (busAddr == A_SYS) sysBits <= busWrData[1:0];
      if (busAddr == A_SRC) srcBit  <= busWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdGo   <= 1'b0;
      cmdRd   <= 1'b0;
      cmdAddr <= '0;
      cmdData <= '0;
    end else if (launchW) begin
      cmdGo   <= 1'b1;
      cmdRd   <= busWrData[CMD_RD_BIT];
      cmdAddr <= busWrData[CMD_A_LSB +: DRP_AW];
      cmdData <= busWrData[DRP_DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         statData <= '0;
    else if (captureW) statData <= drpRdData;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_SYS:  busRdData[1:0] = sysBits;
      A_SRC:  busRdData[0]   = srcBit;
      A_CMD: begin
        busRdData[CMD_GO_BIT]            = cmdGo;
        busRdData[CMD_RD_BIT]            = cmdRd;
        busRdData[CMD_A_LSB +: DRP_AW]   = cmdAddr;
        busRdData[DRP_DW-1:0]            = cmdData;
      end
      A_STAT: begin
        busRdData[STAT_BUSY]  = busy;
        busRdData[DRP_DW-1:0] = statData;
      end
      default: busRdData = '0;
    endcase
  end

  // R7
  rd_data_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statData) |-> $past(captureW));
  // R8
  addr_only_on_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(drpAddr) |-> $past(launchW));
  // R3
  src_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(srcSel) |-> $past(busWrEn));
endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int BUS_DW = 32,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_DW-1:0] busWrData,
  output logic [BUS_DW-1:0] busRdData,
  output logic              coreRelease,
  output logic              synthEnable,
  output logic              srcSel,
  output logic              drpEn,
  output logic              drpWe,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpWrData,
  input  logic              drpRdy,
  input  logic [DRP_DW-1:0] drpRdData
);
  drpStrobes_t strb;
  logic        busy;
  logic        cmdReq;
  logic        cmdIsRead;

  drp_bridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .cmdIsRead(cmdIsRead),
    .drpRdy(drpRdy), .strb(strb), .busy(busy), .drpEn(drpEn), .drpWe(drpWe)
  );

  drp_bridge_dp #(
    .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .strb(strb), .busy(busy),
    .cmdReq(cmdReq), .cmdIsRead(cmdIsRead), .coreRelease(coreRelease),
    .synthEnable(synthEnable), .srcSel(srcSel), .drpAddr(drpAddr),
    .drpWrData(drpWrData), .drpRdData(drpRdData)
  );
endmodule

// File: tb/drp_bridge_bench.sv
module drp_bridge_bench;
  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        coreRelease, synthEnable, srcSel, drpEn, drpWe;
  logic [6:0]  drpAddr;
  logic [15:0] drpWrData;
  logic        drpRdy;
  logic [15:0] drpRdData = 16'h0;

  always #(CLK_P/2) clk = ~clk;

  drp_bridge u_drp_bridge (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .coreRelease(coreRelease),
    .synthEnable(synthEnable), .srcSel(srcSel), .drpEn(drpEn), .drpWe(drpWe),
    .drpAddr(drpAddr), .drpWrData(drpWrData), .drpRdy(drpRdy),
    .drpRdData(drpRdData)
  );

  int checks = 0;
  int fails = 0;
  bit running = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // port responder
  int   respDelay = 2;
  int   respCnt = 0;
  logic respRdy = 1'b0;
  logic spurRdy = 1'b0;
  logic [15:0] rdPat = 16'h5A3C;
  assign drpRdy = respRdy | spurRdy;

  always @(negedge clk) begin
    respRdy <= 1'b0;
    rdPat   <= rdPat + 16'h1357;
    drpRdData <= rdPat;
    if (respCnt > 0) begin
      respCnt--;
      if (respCnt == 0) respRdy <= 1'b1;
    end else if (drpEn === 1'b1) begin
      respCnt = respDelay;
    end
  end

  // behavioural reference
  logic [1:0]  mSys;
  logic        mSrc, mBusy, mPend, mEn, mWe, mGo, mRd, wasBusy;
  logic [6:0]  mAddr;
  logic [15:0] mWr, mData;

  always @(posedge clk) begin
    if (!rstN) begin
      mSys = 0; mSrc = 0; mBusy = 0; mPend = 0; mEn = 0; mWe = 0;
      mGo = 0; mRd = 0; mAddr = 0; mWr = 0; mData = 0;
    end else begin
      wasBusy = mBusy;
      mEn = 0; mWe = 0;
      if (mBusy && drpRdy) begin
        mBusy = 0;
        if (mPend) mData = drpRdData;
        mPend = 0;
      end
      if (busWrEn) begin
        if (busAddr == 8'h40) mSys = busWrData[1:0];
        if (busAddr == 8'h44) mSrc = busWrData[0];
        if (busAddr == 8'h70 && busWrData[29] && !wasBusy) begin
          mEn = 1; mWe = !busWrData[28]; mBusy = 1; mPend = busWrData[28];
          mGo = 1; mRd = busWrData[28]; mAddr = busWrData[22:16];
          mWr = busWrData[15:0];
        end
      end
    end
  end

  function automatic logic [31:0] mRead(input logic [7:0] a);
    case (a)
      8'h40:   return {30'b0, mSys};
      8'h44:   return {31'b0, mSrc};
      8'h70:   return {2'b0, mGo, mRd, 5'b0, mAddr, mWr};
      8'h74:   return {15'b0, mBusy, mData};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rdTag(input logic [7:0] a);
    case (a)
      8'h40:   return "R2 readback";
      8'h44:   return "R3 readback";
      8'h70:   return "R9 readback";
      8'h74:   return "R5/R7 status";
      default: return "R10 unmapped";
    endcase
  endfunction

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (running) begin
      check("R2 coreRelease", 32'(coreRelease), 32'(mSys[0]));
      check("R2 synthEnable", 32'(synthEnable), 32'(mSys[1]));
      check("R3 srcSel", 32'(srcSel), 32'(mSrc));
      check("R4 drpEn", 32'(drpEn), 32'(mEn));
      check("R4 drpWe", 32'(drpWe), 32'(mWe));
      check("R4 drpAddr", 32'(drpAddr), 32'(mAddr));
      check("R4 drpWrData", 32'(drpWrData), 32'(mWr));
      check(rdTag(busAddr), busRdData, mRead(busAddr));
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a);
    @(negedge clk);
    busAddr = a;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      busAddr = 8'h74;
      #(CLK_P/8);
      if (busRdData[16] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] cmdWord(input bit rd, input logic [6:0] a, input logic [15:0] d);
    return {2'b0, 1'b1, rd, 5'b0, a, d};
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: outputs low during reset
    #(CLK_P/4);
    repeat (2) @(negedge clk);
    check("R1 drpEn in reset", 32'(drpEn), 0);
    check("R1 outputs in reset", {28'b0, coreRelease, synthEnable, srcSel, drpWe}, 0);
    rstN = 1'b1;
    running = 1;
    // R1: all registers zero after reset
    foreach (busAddr[i]) ; // no-op
    begin
      logic [7:0] offs [4] = '{8'h40, 8'h44, 8'h70, 8'h74};
      for (int i = 0; i < 4; i++) begin
        peek(offs[i]);
        #(CLK_P/8);
        check("R1 reset readback", busRdData, 32'h0);
      end
    end
    // R2 / R3
    busWrite(8'h40, 32'h1);
    busWrite(8'h40, 32'h3);
    peek(8'h40); #(CLK_P/8);
    check("R2 enable value", busRdData, 32'h3);
    busWrite(8'h40, 32'hFFFF_FFFC);
    busWrite(8'h44, 32'h1);
    peek(8'h44); #(CLK_P/8);
    check("R3 select one", busRdData, 32'h1);
    busWrite(8'h44, 32'hFFFF_FFFE);
    busWrite(8'h44, 32'h1);
    // R10 unmapped
    busWrite(8'h20, 32'hFFFF_FFFF);
    busWrite(8'h48, 32'hFFFF_FFFF);
    peek(8'h48); #(CLK_P/8);
    check("R10 unmapped read", busRdData, 32'h0);
    peek(8'h44); #(CLK_P/8);
    check("R10 no side effect", busRdData, 32'h1);
    // R4 write transaction
    respDelay = 3;
    busWrite(8'h70, cmdWord(1'b0, 7'h28, 16'h9800));
    waitIdle();
    // R7 read transaction
    respDelay = 1;
    busWrite(8'h70, cmdWord(1'b1, 7'h08, 16'h0000));
    waitIdle();
    // R8 command while busy
    respDelay = 6;
    busWrite(8'h70, cmdWord(1'b1, 7'h16, 16'h0000));
    busWrite(8'h70, cmdWord(1'b0, 7'h4F, 16'hBEEF));
    #(CLK_P/8);
    check("R8 no pulse while busy", 32'(drpEn), 0);
    check("R8 address held", 32'(drpAddr), 32'h16);
    waitIdle();
    // R6 spurious ready while idle
    @(negedge clk); spurRdy = 1'b1;
    @(negedge clk); spurRdy = 1'b0;
    busAddr = 8'h74; #(CLK_P/8);
    check("R6 idle ready ignored", 32'(busRdData[16]), 0);
    // R9 command without go bit
    busWrite(8'h70, 32'h1000_1234);
    #(CLK_P/8);
    check("R9 no launch", 32'(drpEn), 0);
    peek(8'h70); #(CLK_P/8);
    check("R9 command readback", busRdData[22:16], 32'h16);
    // sweep of transactions with mixed delays
    for (int k = 0; k < 24; k++) begin
      respDelay = 1 + (k % 5);
      busWrite(8'h70, cmdWord(k[0], 7'(k * 5 + 3), 16'(k * 16'h0F1D)));
      if (k % 3 == 0) busWrite(8'h70, cmdWord(1'b0, 7'h7F, 16'hFFFF));
      waitIdle();
      peek(8'h70);
    end
    running = 0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule